// File: doc/BRIEF.md
# Bit-Serial Radix-2 Montgomery Multiplier

This block forms the Montgomery product X·Y·2^-n mod M for n-bit unsigned operands. It scans one bit of X per clock. On each cycle it may add Y to a running partial sum, may then add M so that the sum becomes even, and finally halves the sum. After n such steps a single compare-and-subtract brings the value below M.

A caller presents X, Y and M together with a one-cycle start pulse. The caller then waits for the done pulse, which arrives n+1 cycles later and carries the result. The block assumes M is odd and larger than both X and Y. All intermediate arithmetic is zero-extended into an accumulator two bits wider than the operands. Operands whose top bit is set are therefore treated as large positive numbers and never as negative ones. Preparing Montgomery constants and converting values into and out of the Montgomery domain belong to the surrounding logic.

Top module: `mont_mul_r2`

## Requirements
- R1: When done is high, result equals X·Y·2^-n mod M for the X, Y and M captured at the accepted start, given M odd and X, Y < M.
- R2: Operands are unsigned. X, Y and M with bit n-1 set give the same mathematically correct result as small zero-padded values.
- R3: done rises exactly n+1 clock cycles after the rising edge that accepts start, and stays high for exactly one cycle.
- R4: A start pulse that arrives while an operation is in progress is ignored. The running result is unchanged, its done timing is unchanged, and no extra done follows.
- R5: Whenever done is high, result is strictly less than the captured M.
- R6: Intermediate sums never overflow, even when X+Y+M exceeds 2^n. For example, X = Y = M-1 with M = 2^n-1 still gives the correct result, and the internal partial sum stays below 2M.
- R7: After reset, done is 0 and result is 0. Between operations, result holds the last computed value.
- R8: X = 0 or Y = 0 gives a result of 0.
- R9: A start driven in the same cycle that done is high is accepted. Its result follows n+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| x_in | input | WIDTH | Multiplier operand, scanned from bit 0 |
| y_in | input | WIDTH | Multiplicand operand |
| m_in | input | WIDTH | Odd modulus |
| result | output | WIDTH | Montgomery product, valid while done is high and held afterwards |
| done | output | 1 | One-cycle completion pulse |

## Verification
A single wrong add, missed parity correction or dropped carry in any of the n steps propagates through the remaining halvings. It shows up as a wrong result at the done pulse n+1 cycles after start, so every operation is compared against an arithmetic reference that multiplies modulo M and then halves modulo M n times. Sign-extension or width faults stay hidden for small operands and appear only when top bits are set. The sweeps therefore mix full-width moduli and operands with small zero-padded ones. A step counter that is off by one shows up at once as a shifted done pulse and almost always as a wrong value. Both the latency and the value are checked on every operation.

// File: rtl/mont_pkg.sv
package mont_pkg;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_LOOP = 2'd1,
        MS_FIX  = 2'd2
    } mont_state_e;

endpackage

// File: rtl/mont_bit_ctr.sv
// Counts loop iterations; flags the final one.
module mont_bit_ctr #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CW'(WIDTH - 1));

endmodule

// File: rtl/mont_iter.sv
// One radix-2 step: conditional add of Y, parity add of M, halve.
module mont_iter #(
    parameter int WIDTH = 32,
    parameter int ACC_W = WIDTH + 2
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             xbit,
    input  logic [WIDTH-1:0] y,
    input  logic [WIDTH-1:0] m,
    output logic [ACC_W-1:0] acc_next
);
    localparam int PAD = ACC_W - WIDTH;

    logic [ACC_W-1:0] y_ext, m_ext, sum_y, sum_m;

    always_comb begin
        y_ext    = {{PAD{1'b0}}, y};
        m_ext    = {{PAD{1'b0}}, m};
        sum_y    = xbit ? (acc + y_ext) : acc;
        sum_m    = sum_y[0] ? (sum_y + m_ext) : sum_y;
        acc_next = sum_m >> 1;
    end

endmodule

// File: rtl/mont_fix.sv
// Final conditional subtraction bringing the sum below M.
module mont_fix #(
    parameter int WIDTH = 32,
    parameter int ACC_W = WIDTH + 2
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [WIDTH-1:0] m,
    output logic [WIDTH-1:0] res
);
    localparam int PAD = ACC_W - WIDTH;

    logic [ACC_W-1:0] m_ext, diff;
    logic             ge;

    always_comb begin
        m_ext = {{PAD{1'b0}}, m};
        ge    = (acc >= m_ext);
        diff  = acc - m_ext;
        res   = ge ? WIDTH'(diff) : acc[WIDTH-1:0];
    end

endmodule

// File: rtl/mont_mul_r2.sv
module mont_mul_r2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic [WIDTH-1:0] m_in,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    import mont_pkg::*;

    localparam int ACC_W = WIDTH + 2;

    typedef struct packed {
        mont_state_e      state;
        logic [WIDTH-1:0] x;
        logic [WIDTH-1:0] y;
        logic [WIDTH-1:0] m;
        logic [ACC_W-1:0] acc;
        logic [WIDTH-1:0] res;
        logic             done;
    } mont_regs_t;

    mont_regs_t st_d, st_q;

    logic [ACC_W-1:0] acc_step;
    logic [WIDTH-1:0] fix_res;
    logic             iter_last;
    logic             busy_w;
    logic [WIDTH-1:0] m_cap_w;
    logic [ACC_W-1:0] acc_w;

    mont_iter #(.WIDTH(WIDTH), .ACC_W(ACC_W)) u_iter (
        .acc      (st_q.acc),
        .xbit     (st_q.x[0]),
        .y        (st_q.y),
        .m        (st_q.m),
        .acc_next (acc_step)
    );

    mont_fix #(.WIDTH(WIDTH), .ACC_W(ACC_W)) u_fix (
        .acc (st_q.acc),
        .m   (st_q.m),
        .res (fix_res)
    );

    mont_bit_ctr #(.WIDTH(WIDTH)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_q.state == MS_IDLE),
        .step  (st_q.state == MS_LOOP),
        .last  (iter_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            MS_IDLE: begin
                if (start) begin
                    st_d.x     = x_in;
                    st_d.y     = y_in;
                    st_d.m     = m_in;
                    st_d.acc   = '0;
                    st_d.state = MS_LOOP;
                end
            end
            MS_LOOP: begin
                st_d.acc = acc_step;
                st_d.x   = st_q.x >> 1;
                if (iter_last) begin
                    st_d.state = MS_FIX;
                end
            end
            MS_FIX: begin
                st_d.res   = fix_res;
                st_d.done  = 1'b1;
                st_d.state = MS_IDLE;
            end
            default: st_d.state = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: MS_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = st_q.res;
    assign done    = st_q.done;
    assign busy_w  = (st_q.state != MS_IDLE);
    assign m_cap_w = st_q.m;
    assign acc_w   = st_q.acc;

endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
    parameter int WIDTH = 32,
    parameter int ACC_W = WIDTH + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic             busy,
    input logic [WIDTH-1:0] m_cap,
    input logic [ACC_W-1:0] acc
);
    localparam int LW = $clog2(WIDTH + 4) + 1;

    logic [LW-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (!busy && start) begin
            lat_q <= LW'(1);
        end else if (done) begin
            lat_q <= '0;
        end else if (lat_q != '0) begin
            lat_q <= lat_q + LW'(1);
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LW'(WIDTH + 2))); // R3

    AST_RESULT_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < m_cap)); // R5

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (acc < ({2'b00, m_cap} << 1))); // R6

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(m_cap)); // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(result))); // R7

endmodule

bind mont_mul_r2 mont_mul_chk #(.WIDTH(WIDTH), .ACC_W(ACC_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .busy   (busy_w),
    .m_cap  (m_cap_w),
    .acc    (acc_w)
);

// File: tb/mont_mul_r2_tb.sv
module mont_mul_r2_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] x_in = '0, y_in = '0, m_in = '0;
    logic [W-1:0] result;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mont_mul_r2 #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_in(x_in), .y_in(y_in), .m_in(m_in),
        .result(result), .done(done)
    );

    function automatic logic [W-1:0] ref_mont(logic [W-1:0] x, logic [W-1:0] y,
                                              logic [W-1:0] m);
        logic [2*W+1:0] v;
        v = ({{(W+2){1'b0}}, x} * {{(W+2){1'b0}}, y}) % {{(W+2){1'b0}}, m};
        for (int i = 0; i < W; i++) begin
            if (v[0]) v = (v + {{(W+2){1'b0}}, m}) >> 1;
            else      v = v >> 1;
        end
        return v[W-1:0];
    endfunction

    function automatic logic [W-1:0] pick_mod(int i);
        case (i)
            0: return 32'hFFFF_FFFF;
            1: return 32'hFFFF_FFFB;
            2: return 32'h8000_0001;
            3: return 32'hC000_0005;
            4: return 32'hB4D9_216D;
            5: return 32'd3337;
            6: return 32'd13;
            default: return 32'd3;
        endcase
    endfunction

    function automatic logic [W-1:0] pick_opd(int k, logic [W-1:0] m);
        logic [63:0] h;
        case (k)
            0: return '0;
            1: return (m > 1) ? 32'd1 : 32'd0;
            2: return m - 1;
            3: return m - 2;
            4: return m >> 1;
            5: return (m >> 1) + 1;
            default: begin
                h = (64'(k) * 64'h9E37_79B9) ^ {32'h0, m};
                return W'(h % {32'h0, m});
            end
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic launch(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] m);
        x_in = x; y_in = y; m_in = m; start = 1'b1;
    endtask

    // Called at a negedge right after launch; returns at the negedge where done is seen.
    task automatic wait_done(output int lat);
        lat = 0;
        @(posedge clk);
        for (int i = 0; i < W + 20; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            @(posedge clk);
            lat++;
        end
    endtask

    task automatic run_op(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] m, string tag);
        int lat;
        logic [W-1:0] exp;
        exp = ref_mont(x, y, m);
        launch(x, y, m);
        wait_done(lat);
        check(lat == W + 1, "R3 latency", W'(lat), W'(W + 1));
        check(done && result == exp, tag, result, exp);
        check(result < m, "R5 result below M", result, m);
        @(negedge clk);
        check(!done, "R3 done single cycle", W'(done), '0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [W-1:0] exp_a, last_res;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R7 reset done", W'(done), '0);
        check(result == '0, "R7 reset result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: zero operands
        run_op('0, 32'h7FFF_1234, 32'hFFFF_FFFB, "R8 zero X");
        run_op(32'h8123_4567, '0, 32'hFFFF_FFFB, "R8 zero Y");

        // R6: largest sums, full width modulus
        run_op(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R6 no overflow");

        // R1/R2: sweep of moduli and operand patterns
        for (int mi = 0; mi < 8; mi++) begin
            for (int a = 0; a < 12; a++) begin
                for (int b = 0; b < 12; b++) begin
                    logic [W-1:0] m, x, y;
                    m = pick_mod(mi);
                    x = pick_opd(a, m);
                    y = pick_opd(b, m);
                    run_op(x, y, m, (m[W-1] && (x[W-1] || y[W-1])) ?
                           "R2 top bits set" : "R1 product");
                end
            end
        end

        // R7: result held between operations
        last_res = result;
        repeat (5) @(negedge clk);
        check(result == last_res && !done, "R7 result held", result, last_res);

        // R4: start while busy is ignored
        exp_a = ref_mont(32'hDEAD_BEEF, 32'h1234_5677, 32'hFFFF_FFFB);
        launch(32'hDEAD_BEEF, 32'h1234_5677, 32'hFFFF_FFFB);
        lat = 0;
        for (int i = 0; i < W + 20; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 5 || lat == 6 || lat == W + 1) begin
                x_in = 32'h1; y_in = 32'h1; m_in = 32'd13; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        start = 1'b0;
        check(lat == W + 2, "R4 timing unchanged", W'(lat), W'(W + 2));
        check(result == exp_a, "R4 running result kept", result, exp_a);
        for (int i = 0; i < W + 4; i++) begin
            @(negedge clk);
            if (done) begin
                check(1'b0, "R4 no extra done", W'(1), '0);
                break;
            end
        end
        check(result == exp_a, "R4 result after busy start", result, exp_a);

        // R9: back-to-back start in the done cycle
        launch(32'h8000_0003, 32'hF000_0001, 32'hFFFF_FFFF);
        wait_done(lat);
        exp_a = ref_mont(32'h8000_0003, 32'hF000_0001, 32'hFFFF_FFFF);
        check(result == exp_a, "R9 first result", result, exp_a);
        launch(32'd1570, 32'd1019, 32'd3337);
        wait_done(lat);
        exp_a = ref_mont(32'd1570, 32'd1019, 32'd3337);
        check(lat == W + 1, "R9 chained latency", W'(lat), W'(W + 1));
        check(done && result == exp_a, "R9 chained result", result, exp_a);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule